// File: doc/BRIEF.md
# Serial Pseudo-Static RAM Power-Up Identification Sequencer

This block brings a serial pseudo-static RAM into a known state after power-up, before any normal traffic is allowed. It drives its own chip select, serial clock and four data lines. One `start` pulse launches a fixed series of command frames. The first frame forces the device out of four-bit mode, and it is sent four bits per clock. The next frame reads the 24-bit identifier in one-bit mode. The sequence then sends a two-frame reset and finally the command that switches the device into four-bit mode.

The identifier is checked against a known-good-die byte. A bad first read is retried exactly once. A second bad read ends the sequence with an error. From a good identifier the block decodes a size code and detects the early 32 Mbit revision. That revision needs one extra serial clock after each deselect, and the block keeps that mode for it. Results are held on status outputs until the next `start`.

Top module: `psram_init_seq`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `dq_oe` is 0, and `busy`, `done`, `error`, `size_code` and `early_rev` are all 0.
- R2: The first frame sends 0xF5 in two serial clocks with all four lines driven (`dq_oe`=4'hF). Bits [7:4] go out on the first clock and bits [3:0] on the second.
- R3: An identifier frame is one-bit mode, lasts 56 clocks and drives only line 0 (`dq_oe`=4'h1). It sends 0x9F MSB first, then 24 zero bits. For the last 24 clocks `dq_oe` is 0 and `dq_i[1]` is sampled on each rising `sclk`. The first received byte lands in `dev_id[7:0]`, the second in [15:8] and the third in [23:16], each MSB first.
- R4: An identifier is good only when `dev_id[15:8]` is 0x5D. After a bad first read, exactly one more identifier frame is sent. A second bad read sets `error`, sends no further frame and leaves `done` at 0.
- R5: With a good identifier, the extended byte is E=`dev_id[23:16]`. `size_code` takes E[7:5] when that is 0 (16 Mbit), 1 (32 Mbit) or 2 (64 Mbit).
- R6: An extended byte of 0x26 gives `size_code` 2, despite its E[7:5] being 1.
- R7: `early_rev` is 1 exactly when the identifier is good and E is 0x20.
- R8: After a good identifier, the block sends three more one-bit frames of 8 clocks each, in this order: 0x66, then 0x99, then 0x35. It then sets `done`.
- R9: After each frame, one extra `sclk` pulse is given while `cs_n` is high. This always happens for the four-bit exit frame and the identifier frames. For the reset and enter frames it happens only when `early_rev` is 1.
- R10: `cs_n` stays high for at least two system clocks between frames.
- R11: `busy` is high from the cycle after an accepted `start` until the result is posted. A `start` while busy has no effect on the frames or the results. A `start` after completion clears the old results and runs the whole sequence again.
- R12: `size_code` is 3 for any other good identifier. After an error, `size_code` and `early_rev` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| cs_n | output | 1 | Device chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| dq_o | output | 4 | Data out; line 0 carries one-bit commands |
| dq_oe | output | 4 | Per-line output enable |
| dq_i | input | 4 | Data in; line 1 carries one-bit read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully |
| error | output | 1 | Identifier invalid on both reads |
| size_code | output | 2 | 0=16 Mbit, 1=32 Mbit, 2=64 Mbit, 3=unknown |
| early_rev | output | 1 | Early 32 Mbit revision, extra-clock mode kept |
| dev_id | output | 24 | Last identifier word read |

## Verification
The bench sweeps all 256 extended-byte values behind a good die byte. This checks the size decode around the 0x26 override, and the 0x20 revision flag with its extra deselect clocks. A decoder that only looked at E[7:5] would report 32 Mbit for 0x26. A block that dropped the extra clock too early would pulse `sclk` a different number of times after the reset frames. Retry cases place 0x5D in the wrong byte of the response. A block that assembled the bytes in the wrong order would accept those words, or would report a `dev_id` that does not match what was sent. A double failure must stop after three frames with size and revision cleared. A `start` pulse in the middle of the identifier read must leave the frame record unchanged.

// File: rtl/psram_init_seq.sv
module psram_init_seq #(
  parameter int HALF_CYC = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        cs_n,
  output logic        sclk,
  output logic [3:0]  dq_o,
  output logic [3:0]  dq_oe,
  input  logic [3:0]  dq_i,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [1:0]  size_code,
  output logic        early_rev,
  output logic [23:0] dev_id
);

  localparam int CMAX = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
  localparam int CW   = $clog2(CMAX) + 1;
  localparam int ID_RX_BITS = 24;
  localparam int ID_SLOTS   = 8 + 24 + ID_RX_BITS;

  localparam logic [2:0] ST_IDLE = 3'd0, ST_LOAD = 3'd1, ST_XFER = 3'd2,
                         ST_TAIL = 3'd3, ST_GAP  = 3'd4, ST_FIN  = 3'd5;
  localparam logic [2:0] SP_EXIT = 3'd0, SP_ID = 3'd1, SP_RSTEN = 3'd2,
                         SP_RST  = 3'd3, SP_QEN = 3'd4;

  logic [2:0]    state, step;
  logic [31:0]   tx_sr;
  logic [23:0]   rx_sr;
  logic [5:0]    slots;
  logic [CW-1:0] cnt;
  logic          quad, hi, retry;
  logic          cs_q, sclk_q, done_q, err_q, early_q;
  logic [1:0]    size_q;
  logic [23:0]   id_q;

  logic [23:0] id_now;
  logic [7:0]  eid;
  logic        kgd_ok, rx_phase, tail_en;
  logic [1:0]  size_dec;
  logic        unused_in;

  assign unused_in = ^{dq_i[3:2], dq_i[0]};
  assign id_now    = {rx_sr[7:0], rx_sr[15:8], rx_sr[23:16]};
  assign eid       = id_now[23:16];
  assign kgd_ok    = (id_now[15:8] == 8'h5D);
  assign rx_phase  = (step == SP_ID) && (slots <= 6'(ID_RX_BITS));
  assign tail_en   = (step == SP_EXIT) || (step == SP_ID) || early_q;

  always_comb begin
    if (eid == 8'h26) size_dec = 2'd2;
    else begin
      case (eid[7:5])
        3'd0:    size_dec = 2'd0;
        3'd1:    size_dec = 2'd1;
        3'd2:    size_dec = 2'd2;
        default: size_dec = 2'd3;
      endcase
    end
  end

  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign dq_o      = quad ? tx_sr[31:28] : {3'b000, tx_sr[31]};
  assign dq_oe     = (state != ST_XFER) ? 4'h0 :
                     quad ? 4'hF : (rx_phase ? 4'h0 : 4'h1);
  assign busy      = (state != ST_IDLE) && (state != ST_FIN);
  assign done      = done_q;
  assign error     = err_q;
  assign size_code = size_q;
  assign early_rev = early_q;
  assign dev_id    = id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      step    <= SP_EXIT;
      tx_sr   <= '0;
      rx_sr   <= '0;
      slots   <= '0;
      cnt     <= '0;
      quad    <= 1'b0;
      hi      <= 1'b0;
      retry   <= 1'b0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      early_q <= 1'b0;
      size_q  <= 2'd0;
      id_q    <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_FIN: begin
          if (start) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            early_q <= 1'b0;
            size_q  <= 2'd0;
            id_q    <= '0;
            retry   <= 1'b0;
            step    <= SP_EXIT;
            state   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          quad  <= (step == SP_EXIT);
          slots <= (step == SP_EXIT) ? 6'd2 :
                   (step == SP_ID)   ? 6'(ID_SLOTS) : 6'd8;
          case (step)
            SP_EXIT:  tx_sr <= {8'hF5, 24'h0};
            SP_ID:    tx_sr <= {8'h9F, 24'h0};
            SP_RSTEN: tx_sr <= {8'h66, 24'h0};
            SP_RST:   tx_sr <= {8'h99, 24'h0};
            default:  tx_sr <= {8'h35, 24'h0};
          endcase
          hi    <= 1'b0;
          cnt   <= CW'(HALF_CYC - 1);
          cs_q  <= 1'b0;
          state <= ST_XFER;
        end
        ST_XFER: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            cnt <= CW'(HALF_CYC - 1);
            if (!hi) begin
              sclk_q <= 1'b1;
              hi     <= 1'b1;
              if (rx_phase) rx_sr <= {rx_sr[22:0], dq_i[1]};
            end else begin
              sclk_q <= 1'b0;
              hi     <= 1'b0;
              tx_sr  <= quad ? {tx_sr[27:0], 4'h0} : {tx_sr[30:0], 1'b0};
              slots  <= slots - 1'b1;
              if (slots == 6'd1) begin
                cs_q <= 1'b1;
                if (tail_en) state <= ST_TAIL;
                else begin
                  state <= ST_GAP;
                  cnt   <= CW'(GAP_CYC - 1);
                end
              end
            end
          end
        end
        ST_TAIL: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!hi) begin
            sclk_q <= 1'b1;
            hi     <= 1'b1;
            cnt    <= CW'(HALF_CYC - 1);
          end else begin
            sclk_q <= 1'b0;
            hi     <= 1'b0;
            cnt    <= CW'(GAP_CYC - 1);
            state  <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            state <= ST_LOAD;
            case (step)
              SP_EXIT:  step <= SP_ID;
              SP_ID: begin
                id_q <= id_now;
                if (kgd_ok) begin
                  early_q <= (eid == 8'h20);
                  size_q  <= size_dec;
                  step    <= SP_RSTEN;
                end else if (!retry) begin
                  retry <= 1'b1;
                end else begin
                  err_q <= 1'b1;
                  state <= ST_FIN;
                end
              end
              SP_RSTEN: step <= SP_RST;
              SP_RST:   step <= SP_QEN;
              default: begin
                done_q <= 1'b1;
                state  <= ST_FIN;
              end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

module psram_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] dq_oe,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic [1:0] size_code,
  input logic       early_rev
);
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n); // R10
  AST_SELECT_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> !sclk); // R9
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> dq_oe == 4'h0); // R3
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R4
  AST_EARLY_SIZE: assert property (@(posedge clk) disable iff (!rst_n) early_rev |-> size_code == 2'd1); // R7
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) error |-> (size_code == 2'd0 && !early_rev)); // R12
  AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (!done && !error)); // R11
endmodule

bind psram_init_seq psram_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq_oe(dq_oe),
  .busy(busy), .done(done), .error(error), .size_code(size_code),
  .early_rev(early_rev)
);

// File: tb/psram_init_seq_test.sv
module psram_init_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cs_n, sclk, busy, done, error, early_rev;
  logic [3:0] dq_o, dq_oe, dq_i;
  logic [1:0] size_code;
  logic [23:0] dev_id;

  always #4 clk = ~clk;

  psram_init_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sclk(sclk),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .busy(busy), .done(done),
    .error(error), .size_code(size_code), .early_rev(early_rev), .dev_id(dev_id)
  );

  int checks = 0, fails = 0;
  logic [23:0] id_a = '0, id_b = '0;

  int nfr, rises, falls, tailc, gapc, min_gap, idn;
  logic [7:0] op;
  bit qf, bad, sclk_p = 1'b0, cs_p = 1'b1, miso = 1'b0;
  logic [7:0] fop [0:7];
  int frise [0:7];
  int ftail [0:7];
  bit fquad [0:7];
  bit fbad  [0:7];

  assign dq_i = {2'b00, miso, 1'b0};

  always @(negedge clk) begin
    if (start && !busy) begin
      nfr = 0; tailc = 0; min_gap = 999; idn = 0;
    end
    if (cs_p && !cs_n) begin
      if (nfr > 0 && nfr <= 8) ftail[nfr-1] = tailc;
      if (nfr > 0 && gapc < min_gap) min_gap = gapc;
      tailc = 0; rises = 0; falls = 0; op = 8'h00; qf = 1'b0; bad = 1'b0;
    end
    if (!cs_p && cs_n) begin
      if (nfr < 8) begin
        fop[nfr] = op; frise[nfr] = rises; fquad[nfr] = qf; fbad[nfr] = bad;
      end
      if (op == 8'h9F) idn++;
      nfr++;
      gapc = 0;
    end
    if (!cs_n) begin
      if (!sclk_p && sclk) begin
        if (dq_oe == 4'hF) begin op = {op[3:0], dq_o}; qf = 1'b1; end
        else if (rises < 8) op = {op[6:0], dq_o[0]};
        else if (rises < 32) begin if (dq_o[0] || dq_oe != 4'h1) bad = 1'b1; end
        else if (dq_oe != 4'h0) bad = 1'b1;
        rises++;
      end
      if (sclk_p && !sclk) begin
        falls++;
        if (falls >= 32 && falls < 56) begin
          automatic int b = falls - 32;
          automatic logic [23:0] w = (idn == 0) ? id_a : id_b;
          miso = w[8*(b/8) + 7 - (b%8)];
        end else miso = 1'b0;
      end
    end else begin
      if (!sclk_p && sclk) tailc++;
      gapc++;
    end
    sclk_p = sclk;
    cs_p = cs_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_seq(input logic [23:0] a, input logic [23:0] b, input bit mid);
    logic [7:0] eop [0:7];
    int erise [0:7];
    int etail [0:7];
    bit va, vb, ok, early;
    int en, esz;
    logic [23:0] used;
    logic [7:0] e;
    id_a = a; id_b = b;
    pulse_start();
    @(negedge clk);
    chk(busy && !done && !error, "R11 busy after start", {busy, done, error}, 3'b100);
    if (mid) begin
      repeat (60) @(posedge clk);
      pulse_start();
    end
    for (int i = 0; i < 5000 && !(done || error); i++) @(negedge clk);
    va = (a[15:8] == 8'h5D);
    vb = (b[15:8] == 8'h5D);
    ok = va || vb;
    used = va ? a : b;
    e = used[23:16];
    early = ok && (e == 8'h20);
    esz = !ok ? 0 : (e == 8'h26) ? 2 : (e[7:5] <= 3'd2) ? int'(e[7:5]) : 3;
    en = 0;
    eop[en] = 8'hF5; erise[en] = 2; etail[en] = 1; en++;
    eop[en] = 8'h9F; erise[en] = 56; etail[en] = 1; en++;
    if (!va) begin eop[en] = 8'h9F; erise[en] = 56; etail[en] = 1; en++; end
    if (ok) begin
      eop[en] = 8'h66; erise[en] = 8; etail[en] = early; en++;
      eop[en] = 8'h99; erise[en] = 8; etail[en] = early; en++;
      eop[en] = 8'h35; erise[en] = 8; etail[en] = early; en++;
    end
    if (nfr > 0 && nfr <= 8) ftail[nfr-1] = tailc;
    chk(nfr == en, "R4 R8 frame count", nfr, en);
    for (int i = 0; i < en && i < nfr && i < 8; i++) begin
      chk(fop[i] == eop[i], "R2 R3 R8 opcode", fop[i], eop[i]);
      chk(frise[i] == erise[i], "R3 clocks per frame", frise[i], erise[i]);
      chk(fquad[i] == (i == 0), "R2 line width", fquad[i], (i == 0));
      chk(!fbad[i], "R3 address zero and read release", fbad[i], 0);
      chk(ftail[i] == etail[i], "R9 deselect clock", ftail[i], etail[i]);
    end
    chk(min_gap >= 2, "R10 deselect gap", min_gap, 2);
    chk(done == ok && error == !ok && !busy, "R4 result flags", {busy, done, error}, {1'b0, ok, !ok});
    chk(dev_id == used, "R3 byte order", dev_id, used);
    chk(size_code == 2'(esz), "R5 R6 R12 size", size_code, esz);
    chk(early_rev == early, "R7 revision flag", early_rev, early);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && dq_oe == 0 && !busy && !done && !error && size_code == 0 && !early_rev,
        "R1 reset state", {cs_n, sclk, dq_oe, busy, done, error, size_code, early_rev}, 12'h800);
    for (int e = 0; e < 256; e++)
      run_seq({8'(e), 8'h5D, 8'(e) ^ 8'hA5}, 24'h0, 1'b0);
    run_seq({8'h20, 8'h5C, 8'h11}, {8'h20, 8'h5D, 8'h02}, 1'b0);
    run_seq({8'h5D, 8'h00, 8'h5D}, {8'h26, 8'h5D, 8'h5D}, 1'b0);
    run_seq({8'h20, 8'hDD, 8'h20}, {8'h5D, 8'h5D, 8'h00}, 1'b0);
    run_seq({8'h20, 8'hD5, 8'h5D}, {8'hE0, 8'h7D, 8'h5D}, 1'b0);
    run_seq({8'h40, 8'h5D, 8'h33}, 24'h0, 1'b1);
    run_seq({8'hC0, 8'h5D, 8'h44}, 24'h0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule